// File: doc/BRIEF.md
# I2C Read Responder with Byte Retransmit

This block is a bus target that sits on a two-wire serial bus and answers exactly one kind of transaction: a read addressed to its own fixed 7-bit address. It watches the clock and data lines through synchronising flops, recognises the start and stop conditions, and shifts in the address byte. When the address matches and the direction bit asks for a read, it acknowledges and then returns a single fixed byte.

The data line is open-drain. The block never drives it high. Its only output is an enable that pulls the line low. After the byte has gone out, the block lets go of the line and watches the controller's acknowledge slot. A missing acknowledge does not end the transfer: the same byte is sent again, and again, until the controller acknowledges it. After an acknowledge the block stays quiet until the next start or stop. A start or stop at any point abandons whatever was in progress.

Top module: `i2c_read_responder`

## Requirements
- R1: After reset the pull-down enable is 0 and the block waits for a START condition.
- R2: A START (SDA falls while SCL is high) begins address reception. The block keeps SDA released while the eight address bits are clocked in, and those bits are captured MSB first on SCL rising edges.
- R3: An address byte whose upper seven bits equal TARGET_ADDR (default 0x78) and whose least significant bit is 1 (read) makes the block pull SDA low for the ninth clock (the acknowledge slot).
- R4: Any other address byte gets no acknowledge. This includes 0x78 with bit 0 = 0 (write). SDA then stays released until the next START or STOP.
- R5: After the acknowledge, READ_BYTE (default 0xAA) is sent MSB first. A 0 bit pulls SDA low and a 1 bit releases it. Each bit is set up after SCL falls and held through the SCL high phase.
- R6: During the controller acknowledge slot that follows the eighth data bit, SDA is released.
- R7: If SDA is high at the rising SCL edge of that slot (no acknowledge), the same byte is sent again in full. This repeats without limit.
- R8: If SDA is low at that edge (acknowledge), the block releases SDA and stays silent for any further clocks until a START or STOP.
- R9: A STOP (SDA rises while SCL is high) at any point releases SDA and returns the block to waiting for START. Clock pulses without a preceding START are ignored.
- R10: A repeated START at any point releases SDA and restarts address reception from the first bit.
- R11: The pull-down enable changes only while the synchronised SCL is low. The one exception is the release caused by a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Raw serial clock line level |
| sda_in | input | 1 | Raw serial data line level (wired-AND bus value) |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The checker watches several things on every clock. The pull-down may move only while SCL is low or in answer to a START or STOP. Every START and STOP must be followed by a release. The line must stay quiet in the idle, address and skip phases. An acknowledge is only allowed for the matching read byte, and each transmitted bit must be present at the SCL rise that samples it.

The bench's scenarios cover the rest. It sweeps all 256 address bytes for the correct acknowledge decision. It reads the returned byte value, runs repeated NACK rounds that each bring back the full byte, and checks that the block stays silent after an acknowledge. It also covers recovery when a STOP or repeated START cuts into the data phase. All of these depend on whole sequences of bus activity.

// File: rtl/i2c_rr_pkg.sv
package i2c_rr_pkg;

  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_DECIDE = 3'd2,
    ST_AACK   = 3'd3,
    ST_TX     = 3'd4,
    ST_MACK   = 3'd5,
    ST_SKIP   = 3'd6
  } rr_state_t;

  // True when the received byte selects this target for a read.
  function automatic logic addr_selects(input logic [BYTE_W-1:0] rx,
                                        input logic [BYTE_W-2:0] own);
    return (rx[BYTE_W-1:1] == own) && rx[0];
  endfunction

  // Pull-down level for bit number idx (0 = most significant) of a byte.
  function automatic logic bit_pull(input logic [BYTE_W-1:0] b,
                                    input logic [IDX_W-1:0] idx);
    logic [IDX_W-1:0] pos;
    pos = IDX_W'(BYTE_W - 1) - idx;
    return !b[pos];
  endfunction

  // Last bit position of a byte, as an index value.
  function automatic logic [IDX_W-1:0] last_idx();
    return IDX_W'(BYTE_W - 1);
  endfunction

endpackage

// File: rtl/i2c_rr_sync.sv
module i2c_rr_sync #(
  parameter int WIDTH     = 2,
  parameter int STAGES    = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0] chain [WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain[i] <= {STAGES{RST_VAL}};
      end else begin
        chain[i] <= {chain[i][STAGES-2:0], d[i]};
      end
    end
    assign q[i] = chain[i][STAGES-1];
  end

endmodule

// File: rtl/i2c_rr_events.sv
module i2c_rr_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic evt_start,
  output logic evt_stop,
  output logic evt_scl_rise,
  output logic evt_scl_fall
);

  logic scl_d;
  logic sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  logic scl_held_high;
  assign scl_held_high = scl_s & scl_d;

  assign evt_start    = scl_held_high & sda_d & ~sda_s;
  assign evt_stop     = scl_held_high & ~sda_d & sda_s;
  assign evt_scl_rise = scl_s & ~scl_d;
  assign evt_scl_fall = ~scl_s & scl_d;

endmodule

// File: rtl/i2c_rr_engine.sv
module i2c_rr_engine
  import i2c_rr_pkg::*;
#(
  parameter logic [BYTE_W-2:0] TARGET_ADDR = 7'h78,
  parameter logic [BYTE_W-1:0] READ_BYTE   = 8'hAA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             evt_start,
  input  logic             evt_stop,
  input  logic             evt_scl_rise,
  input  logic             evt_scl_fall,
  output rr_state_t        state,
  output logic [BYTE_W-1:0] addr_byte,
  output logic [IDX_W-1:0] bit_idx,
  output logic             sda_pull
);

  logic [IDX_W-1:0] rx_cnt;
  logic             ack_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_byte <= '0;
      rx_cnt    <= '0;
      bit_idx   <= '0;
      ack_seen  <= 1'b0;
      sda_pull  <= 1'b0;
    end else if (evt_start) begin
      state     <= ST_ADDR;
      addr_byte <= '0;
      rx_cnt    <= '0;
      sda_pull  <= 1'b0;
    end else if (evt_stop) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (evt_scl_rise) begin
            addr_byte <= {addr_byte[BYTE_W-2:0], sda_s};
            rx_cnt    <= rx_cnt + 1'b1;
            if (rx_cnt == last_idx()) state <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          if (evt_scl_fall) begin
            if (addr_selects(addr_byte, TARGET_ADDR)) begin
              sda_pull <= 1'b1;
              state    <= ST_AACK;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (evt_scl_fall) begin
            bit_idx  <= '0;
            sda_pull <= bit_pull(READ_BYTE, '0);
            state    <= ST_TX;
          end
        end
        ST_TX: begin
          if (evt_scl_fall) begin
            if (bit_idx == last_idx()) begin
              sda_pull <= 1'b0;
              state    <= ST_MACK;
            end else begin
              bit_idx  <= bit_idx + 1'b1;
              sda_pull <= bit_pull(READ_BYTE, bit_idx + 1'b1);
            end
          end
        end
        ST_MACK: begin
          if (evt_scl_rise) ack_seen <= ~sda_s;
          if (evt_scl_fall) begin
            if (ack_seen) begin
              state <= ST_SKIP;
            end else begin
              bit_idx  <= '0;
              sda_pull <= bit_pull(READ_BYTE, '0);
              state    <= ST_TX;
            end
          end
        end
        ST_SKIP: ;
        default: begin
          state    <= ST_IDLE;
          sda_pull <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/i2c_read_responder.sv
module i2c_read_responder
  import i2c_rr_pkg::*;
#(
  parameter logic [BYTE_W-2:0] TARGET_ADDR = 7'h78,
  parameter logic [BYTE_W-1:0] READ_BYTE   = 8'hAA,
  parameter int                SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] sync_lines;
  assign raw_lines = {scl_in, sda_in};

  i2c_rr_sync #(
    .WIDTH  (LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_lines),
    .q    (sync_lines)
  );

  // Named internal events, also watched by the bound checker.
  logic scl_s;
  logic sda_s;
  logic evt_start;
  logic evt_stop;
  logic evt_scl_rise;
  logic evt_scl_fall;
  assign scl_s = sync_lines[1];
  assign sda_s = sync_lines[0];

  i2c_rr_events u_events (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .sda_s       (sda_s),
    .evt_start   (evt_start),
    .evt_stop    (evt_stop),
    .evt_scl_rise(evt_scl_rise),
    .evt_scl_fall(evt_scl_fall)
  );

  rr_state_t         phase;
  logic [BYTE_W-1:0] addr_byte;
  logic [IDX_W-1:0]  tx_idx;

  i2c_rr_engine #(
    .TARGET_ADDR(TARGET_ADDR),
    .READ_BYTE  (READ_BYTE)
  ) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_s       (sda_s),
    .evt_start   (evt_start),
    .evt_stop    (evt_stop),
    .evt_scl_rise(evt_scl_rise),
    .evt_scl_fall(evt_scl_fall),
    .state       (phase),
    .addr_byte   (addr_byte),
    .bit_idx     (tx_idx),
    .sda_pull    (sda_pull)
  );

endmodule

// File: rtl/i2c_read_responder_chk.sv
module i2c_read_responder_chk
  import i2c_rr_pkg::*;
#(
  parameter logic [BYTE_W-2:0] TARGET_ADDR = 7'h78,
  parameter logic [BYTE_W-1:0] READ_BYTE   = 8'hAA
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              evt_start,
  input logic              evt_stop,
  input logic              evt_scl_rise,
  input rr_state_t         phase,
  input logic [BYTE_W-1:0] addr_byte,
  input logic [IDX_W-1:0]  tx_idx,
  input logic              sda_pull
);

  assert_pull_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> (!$past(scl_s) || $past(evt_start) || $past(evt_stop)));

  assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop |=> !sda_pull);

  assert_release_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |=> (!sda_pull && phase == ST_ADDR));

  assert_quiet_outside_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_IDLE || phase == ST_ADDR || phase == ST_DECIDE || phase == ST_SKIP)
      |-> !sda_pull);

  assert_ack_needs_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_AACK) |-> (sda_pull && addr_byte == {TARGET_ADDR, 1'b1}));

  assert_master_slot_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_MACK) |-> !sda_pull);

  assert_bit_valid_at_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_TX && evt_scl_rise) |-> (sda_pull == bit_pull(READ_BYTE, tx_idx)));

endmodule

bind i2c_read_responder i2c_read_responder_chk #(
  .TARGET_ADDR(TARGET_ADDR),
  .READ_BYTE  (READ_BYTE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_s       (scl_s),
  .evt_start   (evt_start),
  .evt_stop    (evt_stop),
  .evt_scl_rise(evt_scl_rise),
  .phase       (phase),
  .addr_byte   (addr_byte),
  .tx_idx      (tx_idx),
  .sda_pull    (sda_pull)
);

// File: tb/i2c_read_responder_test.sv
module i2c_read_responder_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int WATCHDOG   = 190000;
  localparam logic [7:0] SEL_BYTE = {7'h78, 1'b1};
  localparam logic [7:0] DATA     = 8'hAA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m_low = 1'b0;
  logic sda_pull;
  logic sda_bus;

  int checks = 0;
  int fails = 0;
  int pull_cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus = !(sda_m_low || sda_pull);

  i2c_read_responder uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_in  (scl_m),
    .sda_in  (sda_bus),
    .sda_pull(sda_pull)
  );

  always @(negedge clk) if (sda_pull === 1'b1) pull_cycles++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m_low = 1'b0;
    wait_clk(HALF);
    scl_m = 1'b1;
    wait_clk(HALF);
    sda_m_low = 1'b1;
    wait_clk(HALF);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m_low = 1'b1;
    wait_clk(HALF);
    scl_m = 1'b1;
    wait_clk(HALF);
    sda_m_low = 1'b0;
    wait_clk(HALF);
  endtask

  // One clock pulse; master drives pull_low, seen is the bus at the end of high.
  task automatic clock_bit(input logic pull_low, output logic seen);
    sda_m_low = pull_low;
    wait_clk(HALF);
    scl_m = 1'b1;
    wait_clk(HALF);
    seen = sda_bus;
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(!b[i], s);
  endtask

  task automatic read_byte(output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b0, s);
      b[i] = s;
    end
  endtask

  initial begin
    wait_clk(WATCHDOG);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic s;
    logic [7:0] rb;
    int p0;

    wait_clk(5);
    // R1: released during and right after reset
    check(sda_pull == 1'b0, "R1 pull in reset", sda_pull, 0);
    rst_n = 1'b1;
    wait_clk(5);
    check(sda_pull == 1'b0, "R1 pull after reset", sda_pull, 0);

    // R2 R3 R4: every address byte, ack expected only for 0x78 read
    for (int b = 0; b < 256; b++) begin
      bus_start();
      p0 = pull_cycles;
      send_byte(8'(b));
      check(pull_cycles == p0, "R2 quiet during address", pull_cycles - p0, 0);
      clock_bit(1'b0, s);
      if (8'(b) == SEL_BYTE) begin
        check(s == 1'b0, "R3 ack for matching read", s, 0);
        read_byte(rb);
        check(rb == DATA, "R5 returned byte", rb, DATA);
        clock_bit(1'b1, s);
      end else begin
        check(s == 1'b1, "R4 no ack for other byte", s, 1);
        p0 = pull_cycles;
        read_byte(rb);
        check(rb == 8'hFF && pull_cycles == p0, "R4 silent after no ack", rb, 8'hFF);
      end
      bus_stop();
    end

    // R6 R7 R8: repeated NACK brings the byte back, ACK ends it
    bus_start();
    send_byte(SEL_BYTE);
    clock_bit(1'b0, s);
    check(s == 1'b0, "R3 ack before retransmit", s, 0);
    for (int k = 0; k < 4; k++) begin
      read_byte(rb);
      check(rb == DATA, "R7 byte resent after nack", rb, DATA);
      clock_bit(1'b0, s);
      check(s == 1'b1, "R6 slot released", s, 1);
    end
    read_byte(rb);
    check(rb == DATA, "R7 byte before ack", rb, DATA);
    clock_bit(1'b1, s);
    p0 = pull_cycles;
    read_byte(rb);
    clock_bit(1'b0, s);
    check(rb == 8'hFF && s == 1'b1 && pull_cycles == p0, "R8 silent after ack", rb, 8'hFF);
    bus_stop();

    // R9: STOP during data phase (first data bit is 1, bus released)
    bus_start();
    send_byte(SEL_BYTE);
    clock_bit(1'b0, s);
    bus_stop();
    wait_clk(4);
    check(sda_pull == 1'b0, "R9 released after stop", sda_pull, 0);
    p0 = pull_cycles;
    send_byte(SEL_BYTE);
    clock_bit(1'b0, s);
    read_byte(rb);
    check(s == 1'b1 && pull_cycles == p0, "R9 clocks without start ignored", pull_cycles - p0, 0);
    scl_m = 1'b1;
    wait_clk(HALF);

    // R10: repeated START during data phase restarts the address
    bus_start();
    send_byte(SEL_BYTE);
    clock_bit(1'b0, s);
    bus_start();
    wait_clk(4);
    check(sda_pull == 1'b0, "R10 released after restart", sda_pull, 0);
    send_byte(8'hEF);
    clock_bit(1'b0, s);
    check(s == 1'b1, "R10 wrong address after restart", s, 1);
    bus_start();
    send_byte(SEL_BYTE);
    clock_bit(1'b0, s);
    check(s == 1'b0, "R10 ack after restart", s, 0);
    read_byte(rb);
    check(rb == DATA, "R10 byte after restart", rb, DATA);
    clock_bit(1'b1, s);
    bus_stop();

    // R4: write to the own address is not acknowledged
    bus_start();
    send_byte({7'h78, 1'b0});
    clock_bit(1'b0, s);
    check(s == 1'b1, "R4 write not acked", s, 1);
    bus_stop();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule